// File: doc/BRIEF.md
# Memory-Mapped Device Command and Status Interface

This block sits between a simple processor register bus and one peripheral device. Software starts an operation by storing a command word to a fixed offset. It follows the operation by loading a status word, and it passes operands and results through a small bank of data words. The device is reached only through a start pulse with the latched command, and it answers with a completion pulse that may carry an error flag.

Software can learn of completion in two ways. It can keep reading the status word until the done flag appears. It can also set an enable bit, which turns the done flag into an interrupt output. The interrupt handler then acknowledges completion by writing a one to the done bit, and that write drops the interrupt. The device can also write results straight into the data words through its own write port.

Top module: `devctl_regs`

## Requirements
- R1: After reset the command word, the status word and every data word read as zero, and irq and dev_start are low.
- R2: A bus write to offset 0x0 while busy is clear does four things: it stores the write data as the command (seen on dev_cmd), it sets busy, it clears done and error, and it drives dev_start high for exactly the one cycle after the write.
- R3: A bus write to offset 0x0 while busy is set has no effect: dev_cmd keeps its value, dev_start stays low and the status word does not change.
- R4: A dev_done pulse while busy clears busy and sets done, and it loads error from dev_err in the same cycle. A dev_done pulse while busy is clear changes nothing. Error stays set until the next accepted command.
- R5: irq is high exactly when done and the interrupt-enable bit are both set. The enable bit is status bit 3, and a status write loads it from write-data bit 3.
- R6: A status write with bit 1 set clears done, which drops irq. A status write with bit 1 clear leaves done alone. If a completion arrives in the same cycle as the clear, the completion wins and done ends up set.
- R7: The status word at offset 0x4 reads busy in bit 0, done in bit 1, error in bit 2, interrupt-enable in bit 3, and zero in all higher bits. A status write cannot set or clear busy or error.
- R8: Data word i (0 to 7) sits at offset 0x8 + 4*i. It reads back the last value written there, and dev_data presents word i in bits [32*i+31:32*i].
- R9: A dev_wr pulse stores dev_wr_data into data word dev_wr_idx. If the bus writes the same word in the same cycle, the device value is kept.
- R10: Offsets from 0x28 upward read as zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| dev_start | output | 1 | One-cycle start pulse to the device |
| dev_cmd | output | 32 | Latched command word |
| dev_done | input | 1 | Completion pulse from the device |
| dev_err | input | 1 | Error flag, sampled with dev_done |
| dev_wr | input | 1 | Device write strobe for a data word |
| dev_wr_idx | input | 3 | Data word index for the device write |
| dev_wr_data | input | 32 | Device write data |
| dev_data | output | 256 | All data words, word i in bits [32*i+31:32*i] |

## Verification
The bench issues a second command while the device is still busy. A controller that fails to lock out that command would overwrite dev_cmd and fire a second start pulse. The bench also sends a completion pulse while the controller is idle, which a careless design would turn into a false done or error. It lines up a done acknowledge with a fresh completion in the same cycle, where a wrong priority would lose the second interrupt. It also collides a bus write with a device write on the same data word, and it checks that status writes of the busy and error bits leave those bits untouched.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

    // word indices (byte offset / 4) of the fixed registers
    localparam int CMD_WORD   = 0;
    localparam int STAT_WORD  = 1;
    localparam int DATA_BASE  = 2;

    // status bit positions
    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;
    localparam int ST_ERR  = 2;
    localparam int ST_IE   = 3;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_CMD  = 2'd1,
        RD_STAT = 2'd2,
        RD_DATA = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/devctl_decode.sv
module devctl_decode
    import devctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NDATA  = 8,
    localparam int IDX_W = $clog2(NDATA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cmd_we_o,
    output logic              stat_we_o,
    output logic              data_we_o,
    output logic [IDX_W-1:0]  data_idx_o,
    output rd_sel_e           rd_sel_o
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              hit_cmd;
    logic              hit_stat;
    logic              hit_data;
    logic              do_wr;

    assign word     = addr_i[ADDR_W-1:2];
    assign hit_cmd  = (word == WORD_W'(CMD_WORD));
    assign hit_stat = (word == WORD_W'(STAT_WORD));
    assign hit_data = (word >= WORD_W'(DATA_BASE)) &&
                      (word <  WORD_W'(DATA_BASE + NDATA));
    assign do_wr    = sel_i && wr_i;

    always_comb begin
        cmd_we_o   = do_wr && hit_cmd;
        stat_we_o  = do_wr && hit_stat;
        data_we_o  = do_wr && hit_data;
        data_idx_o = IDX_W'(word - WORD_W'(DATA_BASE));
        if (hit_cmd)       rd_sel_o = RD_CMD;
        else if (hit_stat) rd_sel_o = RD_STAT;
        else if (hit_data) rd_sel_o = RD_DATA;
        else               rd_sel_o = RD_NONE;
    end

    AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_we_o, stat_we_o, data_we_o})); // R10

endmodule

// File: rtl/devctl_ctrl.sv
module devctl_ctrl
    import devctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we_i,
    input  logic              stat_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              dev_done_i,
    input  logic              dev_err_i,
    output logic [DATA_W-1:0] cmd_o,
    output logic [DATA_W-1:0] status_o,
    output logic              start_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        logic              busy;
        logic              done;
        logic              err;
        logic              ie;
        logic              start;
    } ctrl_t;

    ctrl_t st_d;
    ctrl_t st_q;
    logic  finish;

    assign finish = st_q.busy && dev_done_i;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (st_q.busy) begin
            if (dev_done_i) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.err  = dev_err_i;
            end
        end else if (cmd_we_i) begin
            st_d.cmd   = wdata_i;
            st_d.busy  = 1'b1;
            st_d.done  = 1'b0;
            st_d.err   = 1'b0;
            st_d.start = 1'b1;
        end
        if (stat_we_i) begin
            st_d.ie = wdata_i[ST_IE];
            if (wdata_i[ST_DONE] && !finish) begin
                st_d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o          = '0;
        status_o[ST_BUSY] = st_q.busy;
        status_o[ST_DONE] = st_q.done;
        status_o[ST_ERR]  = st_q.err;
        status_o[ST_IE]   = st_q.ie;
    end

    assign cmd_o   = st_q.cmd;
    assign start_o = st_q.start;
    assign irq_o   = st_q.done && st_q.ie;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R2
    AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> status_o[ST_BUSY]); // R2
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[ST_BUSY] && status_o[ST_DONE])); // R4
    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ST_BUSY] && dev_done_i) |=> (status_o[ST_DONE] && !status_o[ST_BUSY])); // R4
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[ST_BUSY] && !cmd_we_i && !stat_we_i) |=> $stable(status_o)); // R4
    AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we_i && wdata_i[ST_DONE] && !(status_o[ST_BUSY] && dev_done_i)) |=> !irq_o); // R6

endmodule

// File: rtl/devctl_databank.sv
module devctl_databank #(
    parameter int DATA_W = 32,
    parameter int NDATA  = 8,
    localparam int IDX_W = $clog2(NDATA)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we_i,
    input  logic [IDX_W-1:0]        bus_idx_i,
    input  logic [DATA_W-1:0]       bus_wdata_i,
    input  logic                    dev_we_i,
    input  logic [IDX_W-1:0]        dev_idx_i,
    input  logic [DATA_W-1:0]       dev_wdata_i,
    input  logic [IDX_W-1:0]        rd_idx_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [NDATA*DATA_W-1:0] flat_o
);

    logic [NDATA-1:0][DATA_W-1:0] regs_d;
    logic [NDATA-1:0][DATA_W-1:0] regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_we_i) regs_d[bus_idx_i] = bus_wdata_i;
        if (dev_we_i) regs_d[dev_idx_i] = dev_wdata_i;  // device applied last: wins a collision
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rdata_o = regs_q[rd_idx_i];

    for (genvar g = 0; g < NDATA; g++) begin : g_flat
        assign flat_o[g*DATA_W +: DATA_W] = regs_q[g];
    end

    AST_DEV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_we_i && bus_we_i && (dev_idx_i == bus_idx_i))
        |=> (flat_o[$past(dev_idx_i)*DATA_W +: DATA_W] == $past(dev_wdata_i))); // R9

endmodule

// File: rtl/devctl_regs.sv
module devctl_regs
    import devctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int NDATA  = 8,
    localparam int IDX_W = $clog2(NDATA)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    irq,
    output logic                    dev_start,
    output logic [DATA_W-1:0]       dev_cmd,
    input  logic                    dev_done,
    input  logic                    dev_err,
    input  logic                    dev_wr,
    input  logic [IDX_W-1:0]        dev_wr_idx,
    input  logic [DATA_W-1:0]       dev_wr_data,
    output logic [NDATA*DATA_W-1:0] dev_data
);

    logic              cmd_we;
    logic              stat_we;
    logic              data_we;
    logic [IDX_W-1:0]  data_idx;
    rd_sel_e           rd_sel;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] data_rd;

    devctl_decode #(.ADDR_W(ADDR_W), .NDATA(NDATA)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .cmd_we_o   (cmd_we),
        .stat_we_o  (stat_we),
        .data_we_o  (data_we),
        .data_idx_o (data_idx),
        .rd_sel_o   (rd_sel)
    );

    devctl_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we_i   (cmd_we),
        .stat_we_i  (stat_we),
        .wdata_i    (bus_wdata),
        .dev_done_i (dev_done),
        .dev_err_i  (dev_err),
        .cmd_o      (dev_cmd),
        .status_o   (status_w),
        .start_o    (dev_start),
        .irq_o      (irq)
    );

    devctl_databank #(.DATA_W(DATA_W), .NDATA(NDATA)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (data_we),
        .bus_idx_i   (data_idx),
        .bus_wdata_i (bus_wdata),
        .dev_we_i    (dev_wr),
        .dev_idx_i   (dev_wr_idx),
        .dev_wdata_i (dev_wr_data),
        .rd_idx_i    (data_idx),
        .rdata_o     (data_rd),
        .flat_o      (dev_data)
    );

    always_comb begin
        unique case (rd_sel)
            RD_CMD:  bus_rdata = dev_cmd;
            RD_STAT: bus_rdata = status_w;
            RD_DATA: bus_rdata = data_rd;
            default: bus_rdata = '0;
        endcase
    end

    AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == '0) && status_w[ST_BUSY])
        |=> ($stable(dev_cmd) && !dev_start)); // R3
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_w[ST_IE] && status_w[ST_DONE])); // R5

endmodule

// File: tb/tb_devctl_regs.sv
module tb_devctl_regs;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq;
    logic         dev_start;
    logic [31:0]  dev_cmd;
    logic         dev_done = 1'b0;
    logic         dev_err = 1'b0;
    logic         dev_wr = 1'b0;
    logic [2:0]   dev_wr_idx = '0;
    logic [31:0]  dev_wr_data = '0;
    logic [255:0] dev_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    devctl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dev_start(dev_start), .dev_cmd(dev_cmd),
        .dev_done(dev_done), .dev_err(dev_err), .dev_wr(dev_wr),
        .dev_wr_idx(dev_wr_idx), .dev_wr_data(dev_wr_data), .dev_data(dev_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_op(input logic e);
        @(negedge clk);
        dev_done = 1'b1; dev_err = e;
        @(negedge clk);
        dev_done = 1'b0; dev_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(6'h00, v); chk("R1 cmd", v, 32'h0);
        bus_read(6'h04, v); chk("R1 status", v, 32'h0);
        for (int i = 0; i < 8; i++) begin
            bus_read(6'(8 + 4*i), v); chk("R1 data", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 start", {31'b0, dev_start}, 32'h0);
    endtask

    task automatic t_cmd_idle();
        logic [31:0] v;
        bus_write(6'h00, 32'h0000_00A5);
        chk("R2 start high", {31'b0, dev_start}, 32'h1);
        chk("R2 dev_cmd", dev_cmd, 32'hA5);
        bus_read(6'h04, v); chk("R2 busy", v, 32'h1);
        bus_read(6'h00, v); chk("R2 cmd read", v, 32'hA5);
        @(negedge clk);
        chk("R2 start one cycle", {31'b0, dev_start}, 32'h0);
    endtask

    task automatic t_cmd_busy();
        logic [31:0] v;
        bus_write(6'h00, 32'h0000_0033);
        chk("R3 no start", {31'b0, dev_start}, 32'h0);
        chk("R3 cmd kept", dev_cmd, 32'hA5);
        bus_read(6'h04, v); chk("R3 status kept", v, 32'h1);
    endtask

    task automatic t_complete();
        logic [31:0] v;
        finish_op(1'b0);
        bus_read(6'h04, v); chk("R4 done no err", v, 32'h2);
        chk("R5 irq off when disabled", {31'b0, irq}, 32'h0);
        finish_op(1'b1);
        bus_read(6'h04, v); chk("R4 idle done ignored", v, 32'h2);
        bus_write(6'h00, 32'h0000_0011);
        bus_read(6'h04, v); chk("R4 new cmd clears done", v, 32'h1);
        finish_op(1'b1);
        bus_read(6'h04, v); chk("R4 done with err", v, 32'h6);
    endtask

    task automatic t_irq_ack();
        logic [31:0] v;
        bus_write(6'h04, 32'h0000_0008);
        bus_read(6'h04, v); chk("R5 ie set", v, 32'hE);
        chk("R5 irq", {31'b0, irq}, 32'h1);
        bus_write(6'h04, 32'hFFFF_FFFD);
        bus_read(6'h04, v); chk("R7 busy/err not writable", v, 32'hE);
        bus_write(6'h04, 32'h0000_000A);
        bus_read(6'h04, v); chk("R6 done cleared", v, 32'hC);
        chk("R6 irq dropped", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ack_collision();
        logic [31:0] v;
        bus_write(6'h00, 32'h0000_0022);
        bus_read(6'h04, v); chk("R4 err cleared by cmd", v, 32'h9);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h04; bus_wdata = 32'hA;
        dev_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; dev_done = 1'b0;
        bus_read(6'h04, v); chk("R6 completion wins", v, 32'hA);
        chk("R6 irq after collision", {31'b0, irq}, 32'h1);
        bus_write(6'h04, 32'h0000_0002);
        bus_read(6'h04, v); chk("R7 status cleared", v, 32'h0);
        chk("R5 irq off", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_data();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) bus_write(6'(8 + 4*i), 32'h1000_0000 + 32'(i) * 32'h111);
        for (int i = 0; i < 8; i++) begin
            bus_read(6'(8 + 4*i), v); chk("R8 data readback", v, 32'h1000_0000 + 32'(i) * 32'h111);
        end
        chk("R8 dev_data word7", dev_data[7*32 +: 32], 32'h1000_0777);
        chk("R8 dev_data word0", dev_data[31:0], 32'h1000_0000);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(6'h28, 32'hCAFE_F00D);
        bus_write(6'h3C, 32'h1234_5678);
        bus_read(6'h28, v); chk("R10 unmapped read", v, 32'h0);
        bus_read(6'h3C, v); chk("R10 unmapped read top", v, 32'h0);
        bus_read(6'h00, v); chk("R10 cmd untouched", v, 32'h22);
        bus_read(6'h04, v); chk("R10 status untouched", v, 32'h0);
        for (int i = 0; i < 8; i++) begin
            bus_read(6'(8 + 4*i), v); chk("R10 data untouched", v, 32'h1000_0000 + 32'(i) * 32'h111);
        end
    endtask

    task automatic t_dev_write();
        logic [31:0] v;
        @(negedge clk);
        dev_wr = 1'b1; dev_wr_idx = 3'd3; dev_wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        dev_wr = 1'b0;
        bus_read(6'h14, v); chk("R9 device write", v, 32'hDEAD_BEEF);
        @(negedge clk);
        dev_wr = 1'b1; dev_wr_idx = 3'd5; dev_wr_data = 32'h0000_0002;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h1C; bus_wdata = 32'h0000_0001;
        @(negedge clk);
        dev_wr = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(6'h1C, v); chk("R9 device wins collision", v, 32'h2);
        bus_read(6'h18, v); chk("R9 neighbour untouched", v, 32'h1000_0444);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd_idle();
        t_cmd_busy();
        t_complete();
        t_irq_ack();
        t_ack_collision();
        t_data();
        t_unmapped();
        t_dev_write();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule